// File: doc/BRIEF.md
# Wide Synchronous Link Framer

This block holds both ends of a short, wide, single-clock link between two switches. Each cycle the link carries one 16-bit flit, a 4-bit control field and a 4-bit reverse field. The transmit half takes packets from a local source. It sends a routing-tag flit, then the packet's words as body flits, with the last word carried on an end-of-packet flit. When it has nothing to send, or has no credit left, it drives an idle flit.

The receive half decodes each flit's type, rebuilds packet boundaries and queues the useful flits in a small buffer for the local sink. For every buffer slot it frees, it sends a credit pulse back on the reverse lines. It drops data flits that arrive outside a packet and reports each one. A packet that is cut short by a new routing tag is marked on that tag. The transmitter keeps a credit count equal to the free receive slots, so the receive buffer can never overflow.

Top module: `linkFramer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the link output is all zero, `txReady`, `rxValid` and `rxFrameErr` are low, and the reverse output is zero.
- R2: The control field's type code sits in bits 1:0: 00 idle, 01 routing tag, 10 body, 11 end-of-packet. Bits 3:2 are always transmitted as zero. An idle flit carries all-zero data. The transmitter sends idle whenever it has no packet to send or no credit.
- R3: When `txValid` is high with no packet open and credit is available, the next link flit is a routing tag carrying `txRoute`. No data word is consumed by the tag. Each word accepted afterwards (`txValid` and `txReady` high at a clock edge) appears on the link one cycle later as a body flit, or as an end-of-packet flit if `txLast` was high, which closes the packet.
- R4: The transmit credit count starts at BUF_DEPTH after reset and drops by one for every non-idle flit sent. At zero, no flit other than idle is sent and `txReady` stays low. `txReady` is high exactly when a packet is open and credit is nonzero.
- R5: Reverse bit 0 pulses in the cycle after a buffered flit is taken by the sink. Reverse bit 1 pulses in the cycle after an arriving data flit is discarded. Reverse bits 3:2 are zero. The transmitter adds the number of set bits among reverse bits 1:0 to its credit count.
- R6: Routing tags, and body and end-of-packet flits inside an open packet, are delivered in arrival order on `rxData`/`rxKind`, with `rxKind` using the type codes of R2. An entry stays on the outputs until `rxReady` takes it.
- R7: A body or end-of-packet flit that arrives while no packet is open is not delivered, and `rxFrameErr` pulses in the next cycle. Discarding continues until a routing tag arrives.
- R8: A routing tag that arrives while a packet is open is delivered with `rxCut` high. Every other entry has `rxCut` low.
- R9: The receiver decodes only bits 1:0 of the incoming control field. Bits 3:2 do not change how the flit is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both link ends |
| rstN | input | 1 | Active-low synchronous reset |
| txValid | input | 1 | Source has a packet word (or a packet start) to offer |
| txReady | output | 1 | A word offered now is accepted at this edge |
| txRoute | input | FLIT_W | Routing tag sent at packet start |
| txData | input | FLIT_W | Packet data word |
| txLast | input | 1 | Offered word is the last of its packet |
| txLnkData | output | FLIT_W | Outgoing flit data |
| txLnkCtl | output | 4 | Outgoing control field (type in bits 1:0) |
| txLnkCredit | input | 4 | Reverse lines from the far receiver |
| rxLnkData | input | FLIT_W | Incoming flit data |
| rxLnkCtl | input | 4 | Incoming control field |
| rxLnkCredit | output | 4 | Reverse lines to the far transmitter |
| rxValid | output | 1 | A buffered entry is presented |
| rxReady | input | 1 | Sink takes the presented entry |
| rxData | output | FLIT_W | Entry data (route or word) |
| rxKind | output | 2 | Entry type code |
| rxCut | output | 1 | Entry is a tag that cut the previous packet short |
| rxFrameErr | output | 1 | Pulse for each discarded data flit |

## Verification
The bench builds the block with BUF_DEPTH set to 3. This small depth is not a power of two, so the buffer pointers wrap at an odd boundary, and a single stalled sink runs the credit count to zero within a few flits. The transmitter's output is looped back to its own receiver and the credits are looped back too, so the credit round trip, stalls and release under a randomly ready sink all occur. A second mode drives the receive lines directly to produce orphan data flits, a tag that cuts a packet short and a tag with nonzero reserved bits.

// File: rtl/lnkFramerPkg.sv
package lnkFramerPkg;

  typedef enum logic [1:0] {
    FLIT_IDLE = 2'b00,
    FLIT_TAG  = 2'b01,
    FLIT_BODY = 2'b10,
    FLIT_EOP  = 2'b11
  } flitKind_e;

  // strobes from transmit control to transmit datapath
  typedef struct packed {
    logic sendTag;
    logic sendWord;
    logic wordIsEnd;
  } txStrobe_t;

  // strobes from receive control to receive datapath
  typedef struct packed {
    logic push;
    logic cut;
    logic discard;
    logic pop;
  } rxStrobe_t;

endpackage

// File: rtl/txCtrl.sv
module txCtrl
  import lnkFramerPkg::*;
#(
  parameter int BUF_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  logic       txLast,
  input  logic [1:0] creditIn,
  output logic       txReady,
  output txStrobe_t  stb
);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  logic          inBody;
  logic [CW-1:0] credit;
  logic [CW-1:0] gain;
  logic          haveCredit;
  logic          spend;

  assign haveCredit    = (credit != '0);
  assign txReady       = inBody && haveCredit;
  assign stb.sendTag   = !inBody && txValid && haveCredit;
  assign stb.sendWord  = inBody && txValid && haveCredit;
  assign stb.wordIsEnd = txLast;
  assign spend         = stb.sendTag || stb.sendWord;
  assign gain          = CW'(creditIn[0]) + CW'(creditIn[1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBody <= 1'b0;
      credit <= CW'(BUF_DEPTH);
    end else begin
      credit <= credit - CW'(spend) + gain;
      if (stb.sendTag) begin
        inBody <= 1'b1;
      end else if (stb.sendWord && txLast) begin
        inBody <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txPath.sv
module txPath
  import lnkFramerPkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [FLIT_W-1:0] txRoute,
  input  logic [FLIT_W-1:0] txData,
  output logic [FLIT_W-1:0] lnkData,
  output logic [CTL_W-1:0]  lnkCtl
);
  localparam int RSV_W = CTL_W - 2;

  flitKind_e wordKind;
  assign wordKind = stb.wordIsEnd ? FLIT_EOP : FLIT_BODY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lnkData <= '0;
      lnkCtl  <= '0;
    end else if (stb.sendTag) begin
      lnkData <= txRoute;
      lnkCtl  <= {{RSV_W{1'b0}}, FLIT_TAG};
    end else if (stb.sendWord) begin
      lnkData <= txData;
      lnkCtl  <= {{RSV_W{1'b0}}, wordKind};
    end else begin
      lnkData <= '0;
      lnkCtl  <= {{RSV_W{1'b0}}, FLIT_IDLE};
    end
  end

endmodule

// File: rtl/rxCtrl.sv
module rxCtrl
  import lnkFramerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] inKind,
  input  logic       rxReady,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  output rxStrobe_t  stb
);
  logic pktOpen;
  logic isTag;
  logic isData;

  assign isTag  = (inKind == FLIT_TAG);
  assign isData = (inKind == FLIT_BODY) || (inKind == FLIT_EOP);

  assign stb.push    = (isTag || (isData && pktOpen)) && !fifoFull;
  assign stb.cut     = isTag && pktOpen;
  assign stb.discard = isData && !pktOpen;
  assign stb.pop     = rxReady && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktOpen <= 1'b0;
    end else if (isTag) begin
      pktOpen <= 1'b1;
    end else if (inKind == FLIT_EOP) begin
      pktOpen <= 1'b0;
    end
  end

endmodule

// File: rtl/rxPath.sv
module rxPath
  import lnkFramerPkg::*;
#(
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 4,
  parameter int REV_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [FLIT_W-1:0] inData,
  input  logic [1:0]        inKind,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              rxValid,
  output logic [FLIT_W-1:0] rxData,
  output logic [1:0]        rxKind,
  output logic              rxCut,
  output logic              rxFrameErr,
  output logic [REV_W-1:0]  creditOut
);
  localparam int PW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(BUF_DEPTH - 1);

  logic [FLIT_W-1:0] dataMem [BUF_DEPTH];
  logic [1:0]        kindMem [BUF_DEPTH];
  logic              cutMem  [BUF_DEPTH];

  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] nextSlot(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PW'(1);
  endfunction

  assign fifoFull  = (fill == CW'(BUF_DEPTH));
  assign fifoEmpty = (fill == '0);
  assign rxValid   = !fifoEmpty;
  assign rxData    = dataMem[rdPtr];
  assign rxKind    = kindMem[rdPtr];
  assign rxCut     = cutMem[rdPtr];

  always_ff @(posedge clk) begin
    if (stb.push) begin
      dataMem[wrPtr] <= inData;
      kindMem[wrPtr] <= inKind;
      cutMem[wrPtr]  <= stb.cut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      fill       <= '0;
      creditOut  <= '0;
      rxFrameErr <= 1'b0;
    end else begin
      if (stb.push) wrPtr <= nextSlot(wrPtr);
      if (stb.pop)  rdPtr <= nextSlot(rdPtr);
      fill       <= fill + CW'(stb.push) - CW'(stb.pop);
      creditOut  <= {{(REV_W - 2){1'b0}}, stb.discard, stb.pop};
      rxFrameErr <= stb.discard;
    end
  end

endmodule

// File: rtl/linkFramer.sv
module linkFramer
  import lnkFramerPkg::*;
#(
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txValid,
  output logic              txReady,
  input  logic [FLIT_W-1:0] txRoute,
  input  logic [FLIT_W-1:0] txData,
  input  logic              txLast,
  output logic [FLIT_W-1:0] txLnkData,
  output logic [3:0]        txLnkCtl,
  input  logic [3:0]        txLnkCredit,
  input  logic [FLIT_W-1:0] rxLnkData,
  input  logic [3:0]        rxLnkCtl,
  output logic [3:0]        rxLnkCredit,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [FLIT_W-1:0] rxData,
  output logic [1:0]        rxKind,
  output logic              rxCut,
  output logic              rxFrameErr
);
  localparam int CTL_W = 4;
  localparam int REV_W = 4;

  txStrobe_t txStb;
  rxStrobe_t rxStb;
  logic      fifoFull;
  logic      fifoEmpty;
  logic      unusedRsvBits;

  // reserved bits of the incoming control and reverse fields are not decoded
  assign unusedRsvBits = ^{rxLnkCtl[3:2], txLnkCredit[3:2]};

  txCtrl #(.BUF_DEPTH(BUF_DEPTH)) u_txCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .txValid  (txValid),
    .txLast   (txLast),
    .creditIn (txLnkCredit[1:0]),
    .txReady  (txReady),
    .stb      (txStb)
  );

  txPath #(.FLIT_W(FLIT_W), .CTL_W(CTL_W)) u_txPath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (txStb),
    .txRoute (txRoute),
    .txData  (txData),
    .lnkData (txLnkData),
    .lnkCtl  (txLnkCtl)
  );

  rxCtrl u_rxCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .inKind    (rxLnkCtl[1:0]),
    .rxReady   (rxReady),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .stb       (rxStb)
  );

  rxPath #(.FLIT_W(FLIT_W), .BUF_DEPTH(BUF_DEPTH), .REV_W(REV_W)) u_rxPath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (rxStb),
    .inData     (rxLnkData),
    .inKind     (rxLnkCtl[1:0]),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .rxKind     (rxKind),
    .rxCut      (rxCut),
    .rxFrameErr (rxFrameErr),
    .creditOut  (rxLnkCredit)
  );

endmodule

// File: rtl/linkFramerChk.sv
module linkFramerChk #(
  parameter int FLIT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic [FLIT_W-1:0] txData,
  input logic              txLast,
  input logic [FLIT_W-1:0] txLnkData,
  input logic [3:0]        txLnkCtl,
  input logic [3:0]        rxLnkCtl,
  input logic [3:0]        rxLnkCredit,
  input logic              rxValid,
  input logic              rxReady,
  input logic [FLIT_W-1:0] rxData,
  input logic              rxFrameErr
);
  logic seenOpen;

  always_ff @(posedge clk) begin
    if (!rstN) seenOpen <= 1'b0;
    else if (rxLnkCtl[1:0] == 2'b01) seenOpen <= 1'b1;
    else if (rxLnkCtl[1:0] == 2'b11) seenOpen <= 1'b0;
  end

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (txLnkCtl[1:0] == 2'b00) |-> (txLnkData == '0)); // R2

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (txLnkCtl[3:2] == 2'b00) && (rxLnkCredit[3:2] == 2'b00)); // R2

  AST_WORD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !txLast) |=> (txLnkCtl[1:0] == 2'b10) && (txLnkData == $past(txData))); // R3

  AST_END_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> (txLnkCtl[1:0] == 2'b11)); // R3

  AST_POP_CREDIT: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> rxLnkCredit[0]); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))); // R6

  AST_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxLnkCtl[1] && !seenOpen) |=> rxFrameErr); // R7

endmodule

bind linkFramer linkFramerChk #(.FLIT_W(FLIT_W)) u_linkFramerChk (
  .clk         (clk),
  .rstN        (rstN),
  .txValid     (txValid),
  .txReady     (txReady),
  .txData      (txData),
  .txLast      (txLast),
  .txLnkData   (txLnkData),
  .txLnkCtl    (txLnkCtl),
  .rxLnkCtl    (rxLnkCtl),
  .rxLnkCredit (rxLnkCredit),
  .rxValid     (rxValid),
  .rxReady     (rxReady),
  .rxData      (rxData),
  .rxFrameErr  (rxFrameErr)
);

// File: tb/linkFramer_bench.sv
module linkFramer_bench;
  localparam int FW    = 16;
  localparam int DEPTH = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txValid = 1'b0;
  logic [FW-1:0] txRoute = '0;
  logic [FW-1:0] txData = '0;
  logic          txLast = 1'b0;
  logic          rxReady = 1'b1;
  logic          direct = 1'b0;
  logic [FW-1:0] drvData = '0;
  logic [3:0]    drvCtl = '0;

  logic          txReady;
  logic [FW-1:0] txLnkData;
  logic [3:0]    txLnkCtl;
  logic [3:0]    txLnkCredit;
  logic [FW-1:0] rxLnkData;
  logic [3:0]    rxLnkCtl;
  logic [3:0]    rxLnkCredit;
  logic          rxValid;
  logic [FW-1:0] rxData;
  logic [1:0]    rxKind;
  logic          rxCut;
  logic          rxFrameErr;

  assign rxLnkData   = direct ? drvData : txLnkData;
  assign rxLnkCtl    = direct ? drvCtl  : txLnkCtl;
  assign txLnkCredit = direct ? 4'h0    : rxLnkCredit;

  always #10 clk = ~clk;

  linkFramer #(.FLIT_W(FW), .BUF_DEPTH(DEPTH)) u_linkFramer (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
    .txRoute(txRoute), .txData(txData), .txLast(txLast),
    .txLnkData(txLnkData), .txLnkCtl(txLnkCtl), .txLnkCredit(txLnkCredit),
    .rxLnkData(rxLnkData), .rxLnkCtl(rxLnkCtl), .rxLnkCredit(rxLnkCredit),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxKind(rxKind),
    .rxCut(rxCut), .rxFrameErr(rxFrameErr)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit checking = 1'b0;
  int readyMode = 0;

  // reference model state
  int            mCred;
  bit            mBody;
  bit            mOpen;
  bit            mAcc;
  logic [FW-1:0] mLnkData;
  logic [3:0]    mLnkCtl;
  logic [3:0]    mCredOut;
  bit            mErr;
  int            qData[$];
  int            qKind[$];
  int            qCut[$];
  int            stallSeen = 0;
  int            errExpected = 0;
  int            errObserved = 0;

  logic [3:0]    inCtl;
  logic [FW-1:0] inData;
  logic [3:0]    cIn;
  bit            have, sTag, sWord, popNow, pushNow, disc, cutNow;
  int            k;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCred = DEPTH; mBody = 0; mOpen = 0; mAcc = 0;
      mLnkData = '0; mLnkCtl = '0; mCredOut = '0; mErr = 0;
      qData.delete(); qKind.delete(); qCut.delete();
    end else begin
      inCtl  = direct ? drvCtl  : mLnkCtl;
      inData = direct ? drvData : mLnkData;
      cIn    = direct ? 4'h0    : mCredOut;
      have   = (mCred > 0);
      sTag   = !mBody && txValid && have;
      sWord  = mBody && txValid && have;
      mAcc   = sWord;
      if (mBody && txValid && !have) stallSeen++;
      k       = int'(inCtl[1:0]);
      popNow  = rxReady && (qData.size() > 0);
      disc    = (k >= 2) && !mOpen;
      cutNow  = (k == 1) && mOpen;
      pushNow = ((k == 1) || ((k >= 2) && mOpen)) && (qData.size() < DEPTH);
      if (disc) errExpected++;
      if (popNow) begin
        void'(qData.pop_front()); void'(qKind.pop_front()); void'(qCut.pop_front());
      end
      if (pushNow) begin
        qData.push_back(int'(inData)); qKind.push_back(k); qCut.push_back(int'(cutNow));
      end
      if (k == 1) mOpen = 1;
      else if (k == 3) mOpen = 0;
      mCredOut = {2'b00, disc, popNow};
      mErr     = disc;
      mCred    = mCred - int'(sTag || sWord) + int'(cIn[0]) + int'(cIn[1]);
      if (sTag) begin
        mLnkData = txRoute; mLnkCtl = 4'h1; mBody = 1;
      end else if (sWord) begin
        mLnkData = txData; mLnkCtl = txLast ? 4'h3 : 4'h2;
        if (txLast) mBody = 0;
      end else begin
        mLnkData = '0; mLnkCtl = '0;
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk({txLnkCtl, txLnkData} == {mLnkCtl, mLnkData},
          (mLnkCtl[1:0] == 2'b00) ? "R2 idle flit" : "R3 framed flit",
          {12'h0, txLnkCtl, txLnkData}, {12'h0, mLnkCtl, mLnkData});
      chk(txReady == (mBody && mCred > 0), "R4 txReady vs credit",
          32'(txReady), 32'(mBody && mCred > 0));
      chk(rxLnkCredit == mCredOut, "R5 reverse credit", 32'(rxLnkCredit), 32'(mCredOut));
      chk(rxFrameErr == mErr, "R7 frame error pulse", 32'(rxFrameErr), 32'(mErr));
      chk(rxValid == (qData.size() > 0), "R6 rxValid", 32'(rxValid), 32'(qData.size() > 0));
      if (rxValid && qData.size() > 0) begin
        chk({rxKind, rxData} == {qKind[0][1:0], qData[0][FW-1:0]}, "R6 rx entry",
            {14'h0, rxKind, rxData}, {14'h0, qKind[0][1:0], qData[0][FW-1:0]});
        chk(rxCut == qCut[0][0], "R8 cut flag", 32'(rxCut), 32'(qCut[0][0]));
      end
      if (rxFrameErr) errObserved++;
    end
  end

  always @(negedge clk) begin
    case (readyMode)
      0: rxReady = 1'b1;
      1: rxReady = 1'b0;
      default: rxReady = 1'($urandom % 2);
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=%0d expected<=%0d", cycles, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic sendPkt(input logic [FW-1:0] route, input int len, input logic [FW-1:0] base);
    int i = 0;
    txValid = 1'b1;
    txRoute = route;
    txData  = base;
    txLast  = (len == 1);
    while (i < len) begin
      @(negedge clk);
      if (mAcc) begin
        i++;
        if (i < len) begin
          txData = base + FW'(i);
          txLast = (i == len - 1);
        end
      end
    end
    txValid = 1'b0;
    txLast  = 1'b0;
  endtask

  task automatic drvFlit(input logic [3:0] ctl, input logic [FW-1:0] d);
    drvCtl  = ctl;
    drvData = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(txLnkCtl == 4'h0 && txLnkData == '0, "R1 link idle in reset", {12'h0, txLnkCtl, txLnkData}, 32'h0);
    chk(!txReady && !rxValid && !rxFrameErr, "R1 handshakes low in reset",
        {29'h0, txReady, rxValid, rxFrameErr}, 32'h0);
    chk(rxLnkCredit == 4'h0, "R1 reverse zero in reset", 32'(rxLnkCredit), 32'h0);
    rstN = 1'b1;
    checking = 1'b1;
    repeat (4) @(negedge clk);

    // R3: packets of several lengths, sink always ready
    sendPkt(16'hA001, 1, 16'h1000);
    sendPkt(16'hA002, 3, 16'h2000);
    sendPkt(16'hA003, 5, 16'h3000);
    repeat (6) @(negedge clk);

    // R4: sink stalled, credits run out, then a random sink releases them
    readyMode = 1;
    fork
      begin repeat (15) @(negedge clk); readyMode = 2; end
    join_none
    sendPkt(16'hB004, 6, 16'h4000);
    for (int p = 0; p < 8; p++) sendPkt(16'hC000 + 16'(p), 1 + (p % 4), 16'h5000 + 16'(p * 16));
    readyMode = 0;
    repeat (20) @(negedge clk);

    // R7, R8, R9: receive lines driven directly
    direct = 1'b1;
    drvFlit(4'h2, 16'h0B01);
    drvFlit(4'h3, 16'h0B02);
    drvFlit(4'h0, 16'h0000);
    drvFlit(4'hD, 16'h7001);
    drvFlit(4'h2, 16'h0B03);
    drvFlit(4'h1, 16'h7002);
    drvFlit(4'h3, 16'h0B04);
    drvFlit(4'h2, 16'h0B05);
    drvFlit(4'h0, 16'h0000);
    repeat (6) @(negedge clk);
    direct = 1'b0;
    repeat (2) @(negedge clk);

    sendPkt(16'hD005, 4, 16'h6000);
    repeat (20) @(negedge clk);

    chk(stallSeen > 0, "R4 credit stall reached", 32'(stallSeen), 32'h1);
    chk(errObserved == errExpected && errExpected == 3, "R7 discarded flit count",
        32'(errObserved), 32'(errExpected));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule